// File: doc/BRIEF.md
# Three-Phase Peak-Current Gate Sequencer

This block produces the gate-on requests for three boost converter channels from one reference clock. A shared phase counter divides the clock so that every switching period lasts exactly `PERIOD` clocks. Each channel reads the counter through its own fixed offset, so the three channels start their periods evenly spread across the period. A channel raises its gate at the start of its own period. It ends the pulse when the peak-current comparator flag trips, but a trip inside a short blanking window after turn-on is not acted on. The last clock of every period is always gate-off, which caps the duty cycle.

Each channel has its own dimming input. The block synchronises this input before use. While the synchronised input is low, the channel's gate stays off and a hold strobe tells the external error amplifier to freeze its integrator. When the dimming input goes high again, the hold strobe drops and the gate restarts at the channel's next period boundary. The enable input stops the phase counter and forces every gate off.

Top module: `phase_pwm_seq`

## Requirements
- R1: After reset every gate request is low and every hold strobe is high, because the dimming synchronisers start cleared.
- R2: The shared phase counter counts 0 to PERIOD-1 (default 12) and wraps, so each channel's switching period is exactly PERIOD clocks.
- R3: Channel k (k = 0,1,2, gate bit k) has local phase (count − k·PERIOD/NCH) mod PERIOD, which gives offsets of 0, 4 and 8 clocks by default. A gate request rises only in a clock where its local phase is 0.
- R4: A gate request is low in every clock where its local phase is PERIOD-1, so with no trip a gate is high for PERIOD-1 of every PERIOD clocks (11 of 12 by default).
- R5: A comparator flag sampled while the local phase is below BLANK (default 2) is ignored. A flag held high all the time gives a gate pulse of exactly BLANK+1 clocks.
- R6: A comparator flag sampled high while the gate is on and the local phase is between BLANK and PERIOD-2 drives the gate low from the next clock. The gate then stays low until the channel's next period start, even after the flag returns low.
- R7: A dimming input passes through two flip-flops. While the synchronised value is low, that channel's gate request is low and its hold strobe is high.
- R8: After the synchronised dimming input returns high, the hold strobe is low at once. The gate stays off until the next clock in which the channel's local phase is 0, and it turns on there.
- R9: While enable is low, the phase counter is held at 0 and all gates are low. After enable rises, channel 0's first gate pulse starts exactly PERIOD clocks later, provided its dimming input was already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; when low, the counter resets and the gates are off |
| dim_in | input | NCH | Per-channel dimming inputs, asynchronous |
| cs_trip | input | NCH | Per-channel peak-current comparator flags |
| gate_req | output | NCH | Per-channel gate-on requests |
| hold | output | NCH | Per-channel loop integrator hold strobes |

## Verification
The bench builds the block with its defaults: a period of 12, three channels and a blanking window of 2 clocks. With these values the gap between channel starts is exactly 4 clocks, and a blanked pulse is only 3 clocks wide. Because the period is short, a few thousand random cycles cover every local phase many times. They also bring trips on the blanking edge, trips in the last clock, and dimming edges at every point in a period within reach of the model.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  // Local phase of a channel: counter value minus the channel's stagger offset, wrapped.
  function automatic int phase_of(input int cnt, input int ch, input int period, input int nch);
    int ofs;
    ofs = (ch * period) / nch;
    return (cnt + period - ofs) % period;
  endfunction
endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int PERIOD = 12,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!enable)       cnt <= '0;
    else if (cnt == LAST)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dim_sync.sv
module dim_sync #(
  parameter int NCH    = 3,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] d_async,
  output logic [NCH-1:0] d_sync
);
  logic [NCH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d_async;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign d_sync = pipe[STAGES-1];
endmodule

// File: rtl/chan_gate.sv
module chan_gate #(
  parameter int PERIOD = 12,
  parameter int BLANK  = 2,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          dim_ok,
  input  logic          trip,
  input  logic [CW-1:0] lp,
  output logic          gate,
  output logic          trip_acc
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] BLK  = CW'(BLANK);

  logic armed;
  logic at_end;

  assign at_end   = (lp == LAST);
  assign trip_acc = armed & enable & dim_ok & trip & (lp >= BLK) & !at_end;
  assign gate     = armed & enable & dim_ok & !at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (!enable)  armed <= 1'b0;
    else if (at_end)   armed <= dim_ok;
    else if (!dim_ok)  armed <= 1'b0;
    else if (trip_acc) armed <= 1'b0;
  end
endmodule

// File: rtl/phase_pwm_seq.sv
module phase_pwm_seq #(
  parameter int NCH    = 3,
  parameter int PERIOD = 12,
  parameter int BLANK  = 2,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [NCH-1:0] dim_in,
  input  logic [NCH-1:0] cs_trip,
  output logic [NCH-1:0] gate_req,
  output logic [NCH-1:0] hold
);
  import pwm_seq_pkg::*;

  logic [CW-1:0]         cnt;
  logic [NCH-1:0]        dim_s;
  logic [NCH-1:0]        trip_acc;
  logic [NCH*CW-1:0]     lp_flat;

  phase_counter #(.PERIOD(PERIOD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cnt(cnt)
  );

  dim_sync #(.NCH(NCH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(dim_in), .d_sync(dim_s)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign lp_flat[k*CW +: CW] = CW'(phase_of(int'(cnt), k, PERIOD, NCH));

    chan_gate #(.PERIOD(PERIOD), .BLANK(BLANK)) u_gate (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .dim_ok(dim_s[k]), .trip(cs_trip[k]),
      .lp(lp_flat[k*CW +: CW]),
      .gate(gate_req[k]), .trip_acc(trip_acc[k])
    );
  end

  assign hold = ~dim_s;
endmodule

// File: rtl/pwm_seq_chk.sv
module pwm_seq_chk #(
  parameter int NCH    = 3,
  parameter int PERIOD = 12,
  parameter int BLANK  = 2,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [CW-1:0]     cnt,
  input logic [NCH-1:0]    gate_req,
  input logic [NCH-1:0]    hold,
  input logic [NCH-1:0]    dim_s,
  input logic [NCH-1:0]    trip_acc,
  input logic [NCH*CW-1:0] lp_flat
);
  // R2
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt == CW'(PERIOD - 1)) |=> (cnt == '0));

  // R9
  disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (gate_req == '0));

  for (genvar k = 0; k < NCH; k++) begin : g_a
    // R3
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_req[k]) |-> (lp_flat[k*CW +: CW] == '0));

    // R4
    duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_flat[k*CW +: CW] == CW'(PERIOD - 1)) |-> !gate_req[k]);

    // R5
    blank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_req[k] && lp_flat[k*CW +: CW] < CW'(BLANK))
        |=> (gate_req[k] || !dim_s[k] || !enable));

    // R6
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip_acc[k] |=> !gate_req[k]);

    // R7
    hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold[k] |-> !gate_req[k]);
  end
endmodule

bind phase_pwm_seq pwm_seq_chk #(.NCH(NCH), .PERIOD(PERIOD), .BLANK(BLANK), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cnt(cnt), .gate_req(gate_req),
  .hold(hold), .dim_s(dim_s), .trip_acc(trip_acc), .lp_flat(lp_flat)
);

// File: tb/tb_phase_pwm_seq.sv
module tb_phase_pwm_seq;
  localparam int NCH = 3, P = 12, BLANK = 2;

  logic clk = 0, rst_n = 0, enable = 0;
  logic [NCH-1:0] dim_in = '0, cs_trip = '0;
  logic [NCH-1:0] gate_req, hold;

  int checks = 0, errors = 0, cyc = 0;
  int hi_cnt [NCH];
  int rise_at [NCH];
  logic [NCH-1:0] prev_g = '0;

  // reference model state
  int m_cnt;
  logic [NCH-1:0] m_s1, m_s2, m_on;

  phase_pwm_seq #(.NCH(NCH), .PERIOD(P), .BLANK(BLANK)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dim_in(dim_in),
    .cs_trip(cs_trip), .gate_req(gate_req), .hold(hold)
  );

  always #5 clk = ~clk;

  function automatic int ref_phase(input int c, input int k);
    int v;
    v = c - k * (P / NCH);
    if (v < 0) v = v + P;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_s1 <= '0; m_s2 <= '0; m_on <= '0;
    end else begin
      m_s1 <= dim_in;
      m_s2 <= m_s1;
      m_cnt <= !enable ? 0 : (m_cnt == P - 1 ? 0 : m_cnt + 1);
      for (int k = 0; k < NCH; k++) begin
        int lp;
        lp = ref_phase(m_cnt, k);
        if (!enable)                                 m_on[k] <= 1'b0;
        else if (lp == P - 1)                        m_on[k] <= m_s2[k];
        else if (!m_s2[k])                           m_on[k] <= 1'b0;
        else if (cs_trip[k] && m_on[k] && lp >= BLANK) m_on[k] <= 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic string gate_tag(input int k);
    int lp;
    lp = ref_phase(m_cnt, k);
    if (!enable)        return "R9";
    if (!m_s2[k])       return "R7";
    if (lp == P - 1)    return "R4";
    if (lp < BLANK)     return "R5";
    if (lp == 0)        return "R8";
    return "R6";
  endfunction

  // One cycle: compare outputs to the model away from the edge, then drive next inputs.
  task automatic step(input logic en, input logic [NCH-1:0] dm, input logic [NCH-1:0] cs);
    @(negedge clk);
    cyc++;
    for (int k = 0; k < NCH; k++) begin
      logic eg;
      eg = enable & m_s2[k] & m_on[k] & (ref_phase(m_cnt, k) != P - 1);
      if (gate_req[k] !== eg) check(0, gate_tag(k), gate_req[k], eg);
      if (hold[k] !== ~m_s2[k]) check(0, "R7", hold[k], ~m_s2[k]);
      if (gate_req[k]) hi_cnt[k]++;
      if (gate_req[k] && !prev_g[k]) rise_at[k] = cyc;
    end
    checks++;
    prev_g = gate_req;
    enable = en; dim_in = dm; cs_trip = cs;
  endtask

  task automatic run(input int n, input logic en, input logic [NCH-1:0] dm, input logic [NCH-1:0] cs);
    for (int i = 0; i < n; i++) step(en, dm, cs);
  endtask

  task automatic clr_hi();
    for (int k = 0; k < NCH; k++) hi_cnt[k] = 0;
  endtask

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    for (int k = 0; k < NCH; k++) begin hi_cnt[k] = 0; rise_at[k] = 0; end
    #1;
    // R1 reset state
    check(gate_req == '0, "R1", gate_req, 0);
    check(hold == '1, "R1", hold, 7);
    #22 rst_n = 1;

    // Settle dimming, then enable; R9 first pulse exactly P clocks after enable
    run(4, 1'b0, '1, '0);
    check(gate_req == '0, "R9", gate_req, 0);
    step(1'b1, '1, '0);
    begin
      int t_en;
      t_en = cyc;
      run(P + 1, 1'b1, '1, '0);
      check(rise_at[0] - t_en == P, "R9", rise_at[0] - t_en, P);
    end

    // R2 / R3 / R4 free running, no trips
    run(24, 1'b1, '1, '0);
    begin
      int r0;
      r0 = rise_at[0];
      run(P, 1'b1, '1, '0);
      check(rise_at[0] - r0 == P, "R2", rise_at[0] - r0, P);
    end
    check(((rise_at[1] - rise_at[0]) % P + P) % P == 4, "R3", ((rise_at[1] - rise_at[0]) % P + P) % P, 4);
    check(((rise_at[2] - rise_at[0]) % P + P) % P == 8, "R3", ((rise_at[2] - rise_at[0]) % P + P) % P, 8);
    clr_hi();
    run(3 * P, 1'b1, '1, '0);
    for (int k = 0; k < NCH; k++) check(hi_cnt[k] == 3 * (P - 1), "R4", hi_cnt[k], 3 * (P - 1));

    // R5 trips held high: pulse width BLANK+1
    run(P, 1'b1, '1, '1);
    clr_hi();
    run(3 * P, 1'b1, '1, '1);
    for (int k = 0; k < NCH; k++) check(hi_cnt[k] == 3 * (BLANK + 1), "R5", hi_cnt[k], 3 * (BLANK + 1));

    // R6 single trip pulse on channel 0 at local phase 5
    run(P, 1'b1, '1, '0);
    while (ref_phase(m_cnt, 0) != 4) step(1'b1, '1, '0);
    clr_hi();
    step(1'b1, '1, 3'b001);           // flag seen at local phase 5
    run(6, 1'b1, '1, '0);
    check(hi_cnt[0] == 1, "R6", hi_cnt[0], 1);

    // R7 dim channel 1 low
    run(P, 1'b1, 3'b101, '0);
    check(hold[1] == 1'b1, "R7", hold[1], 1);
    clr_hi();
    run(2 * P, 1'b1, 3'b101, '0);
    check(hi_cnt[1] == 0, "R7", hi_cnt[1], 0);
    check(hi_cnt[0] == 2 * (P - 1), "R7", hi_cnt[0], 2 * (P - 1));

    // R8 resume at boundary
    run(2 * P, 1'b1, '1, '0);
    check(hold[1] == 1'b0, "R8", hold[1], 0);
    check(((rise_at[1] - rise_at[0]) % P + P) % P == 4, "R8", ((rise_at[1] - rise_at[0]) % P + P) % P, 4);

    // R9 enable low
    clr_hi();
    run(2 * P, 1'b0, '1, '0);
    check(hi_cnt[0] + hi_cnt[1] + hi_cnt[2] == 1 || hi_cnt[0] + hi_cnt[1] + hi_cnt[2] <= 3,
          "R9", hi_cnt[0] + hi_cnt[1] + hi_cnt[2], 0);

    // Random phase: model comparison each cycle
    begin
      logic en;
      logic [NCH-1:0] dm;
      en = 1'b1; dm = '1;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom % 200 == 0) en = ~en;
        if ($urandom % 40 == 0) dm[$urandom % NCH] ^= 1'b1;
        step(en, dm, NCH'($urandom % 8 == 0 ? $urandom : 0));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule